// File: doc/BRIEF.md
# Daisy-Chained Bus Interrupt Handler

The block sits between four local interrupt sources and a backplane with seven prioritised, active-low interrupt request lines. For each source it holds a configuration (enable, bus level, completion mode) and an interrupt vector. A rising edge on a local request input marks that source pending. While it is pending and enabled, the block pulls the request line for the level it is programmed to.

When a bus handler runs an interrupt-acknowledge cycle, the block captures the level on the address lines and the read/write bit. It then waits for the acknowledge daisy chain to reach it. If no enabled pending source matches, it passes the chain downstream. If a source matches, the block completes the cycle in one of two ways. It can drive the stored vector and then a data-transfer acknowledge itself. Or it can signal the local device, with an enable strobe and a 2-bit source index, to complete the cycle on its own.

Top module: `bus_int_handler`

## Requirements
- R1: A new acknowledge cycle starts only on an edge where the acknowledge input is low after it has been seen high since the last cycle or since reset. At that edge the level and read/write inputs are captured.
- R2: If the daisy-chain input stays negated for the whole acknowledge cycle, no output is driven and no pending request changes.
- R3: With the chain input asserted and no match, the chain output goes low; no vector, DTACK or delegation strobe is driven.
- R4: A source whose enable bit is clear never matches and never pulls a request line.
- R5: An internal-mode match puts that source's vector on the data output with the output enable set. DTACK follows one clock later, and the chain output stays high throughout.
- R6: An external-mode match drives the delegation strobe low with the source index (0 to 3) on the 2-bit code output. It drives no vector, no DTACK and no chain output.
- R7: When several enabled pending sources share the captured level, the lowest-numbered source wins.
- R8: Request line n (bit n-1 of the request output) is low exactly when some enabled pending source is programmed to level n. Level 0 requests no line.
- R9: A rising edge on a source's request input makes it pending. Its pending state clears when DTACK is asserted for it (internal mode) or when the delegation strobe is asserted for it (external mode).
- R10: The chain output, DTACK, delegation strobe and data output enable all release in the same cycle that the acknowledge input goes high.
- R11: A captured write cycle (read/write low) never matches, so the chain is passed on.
- R12: Register port: address bit 2 = 0 selects a source's configuration, 1 its vector, and address bits 1:0 select the source. Configuration bit 7 is the enable, bit 3 is the mode (1 = external) and bits 2:0 are the level. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| req_i | input | 4 | Local interrupt requests, rising edge sets pending |
| irq_no | output | 7 | Bus request lines, bit n-1 is level n, active low |
| iack_ni | input | 1 | Acknowledge cycle in progress, active low |
| iackin_ni | input | 1 | Daisy chain in, active low |
| level_i | input | 3 | Level being acknowledged (address lines) |
| rw_i | input | 1 | Read/write, 1 = read |
| iackout_no | output | 1 | Daisy chain out, active low |
| dtack_no | output | 1 | Data-transfer acknowledge, active low |
| data_o | output | 8 | Vector output |
| data_oe_o | output | 1 | Vector output enable |
| intae_no | output | 1 | Delegation strobe to the local device, active low |
| intal_o | output | 2 | Index of the delegated source |

## Verification
The bench builds the block with its default four sources and 8-bit vectors, which is small enough to sweep 64 register configurations. Each configuration is acknowledged at all seven levels, and the expected winner, vector, mode and request-line pattern are computed arithmetically from the model's own registers. Because pairs of sources share levels in most configurations and all four share one in some, both the priority rule and the progressive clearing of pending requests fall inside the sweep. Skipped daisy chains, write cycles and a held acknowledge after reset are placed at fixed points in the sweep.

// File: rtl/bih_pkg.sv
package bih_pkg;
  localparam int LVL_W = 3;
  localparam int N_LVL = (1 << LVL_W) - 1;

  typedef struct packed {
    logic             en;
    logic             ext;
    logic [LVL_W-1:0] lvl;
  } src_cfg_t;

  typedef enum logic [2:0] {
    ST_WAIT_HI,
    ST_IDLE,
    ST_CHAIN,
    ST_PASS,
    ST_VEC,
    ST_DTK,
    ST_EXT
  } ack_st_e;
endpackage

// File: rtl/bih_regs.sv
module bih_regs
  import bih_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int AW    = IDX_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [VEC_W-1:0]            wdata_i,
  output src_cfg_t [N_SRC-1:0]        cfg_o,
  output logic [N_SRC-1:0][VEC_W-1:0] vec_o
);
  logic             is_vec;
  logic [IDX_W-1:0] sel;

  assign is_vec = addr_i[AW-1];
  assign sel    = addr_i[IDX_W-1:0];

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g] <= '0;
        vec_o[g] <= '0;
      end else if (we_i && sel == IDX_W'(g)) begin
        if (is_vec) vec_o[g] <= wdata_i;
        else begin
          cfg_o[g].en  <= wdata_i[7];
          cfg_o[g].ext <= wdata_i[3];
          cfg_o[g].lvl <= wdata_i[LVL_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/bih_req.sv
module bih_req
  import bih_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SRC-1:0]     req_i,
  input  logic [N_SRC-1:0]     clr_i,
  input  src_cfg_t [N_SRC-1:0] cfg_i,
  output logic [N_SRC-1:0]     pend_o,
  output logic [N_LVL-1:0]     irq_no
);
  logic [N_SRC-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      // a new edge beats a clear in the same cycle
      pend_o <= (pend_o & ~clr_i) | (req_i & ~req_q);
    end
  end

  for (genvar l = 1; l <= N_LVL; l++) begin : g_lvl
    logic [N_SRC-1:0] hit;
    always_comb begin
      for (int i = 0; i < N_SRC; i++)
        hit[i] = pend_o[i] && cfg_i[i].en && cfg_i[i].lvl == LVL_W'(l);
    end
    assign irq_no[l-1] = ~|hit;
  end

  assert_clr_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~pend_o) == '0);
endmodule

// File: rtl/bih_match.sv
module bih_match
  import bih_pkg::*;
#(
  parameter int N_SRC = 4,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  src_cfg_t [N_SRC-1:0] cfg_i,
  input  logic [N_SRC-1:0]     pend_i,
  input  logic [LVL_W-1:0]     lvl_i,
  input  logic                 rd_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     win_o,
  output logic                 ext_o
);
  always_comb begin
    hit_o = 1'b0;
    win_o = '0;
    ext_o = 1'b0;
    // descending scan: the lowest index is written last and wins
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (rd_i && lvl_i != '0 && pend_i[i] && cfg_i[i].en && cfg_i[i].lvl == lvl_i) begin
        hit_o = 1'b1;
        win_o = IDX_W'(i);
        ext_o = cfg_i[i].ext;
      end
    end
  end
endmodule

// File: rtl/bih_ack.sv
module bih_ack
  import bih_pkg::*;
#(
  parameter int N_SRC = 4,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               iack_ni,
  input  logic               iackin_ni,
  input  logic [LVL_W-1:0]   level_i,
  input  logic               rw_i,
  output logic [LVL_W-1:0]   cap_lvl_o,
  output logic               cap_rd_o,
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   win_i,
  input  logic               ext_i,
  output logic [IDX_W-1:0]   win_o,
  output logic [N_SRC-1:0]   clr_o,
  output logic               iackout_no,
  output logic               dtack_no,
  output logic               data_oe_o,
  output logic               intae_no
);
  ack_st_e st_q, st_d;
  logic    take_ext;

  assign take_ext = st_q == ST_CHAIN && !iack_ni && !iackin_ni && hit_i && ext_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT_HI: if (iack_ni) st_d = ST_IDLE;
      ST_IDLE:    if (!iack_ni) st_d = ST_CHAIN;
      ST_CHAIN: begin
        if (iack_ni)         st_d = ST_IDLE;
        else if (!iackin_ni) st_d = !hit_i ? ST_PASS : (ext_i ? ST_EXT : ST_VEC);
      end
      ST_VEC:     st_d = iack_ni ? ST_IDLE : ST_DTK;
      ST_PASS, ST_DTK, ST_EXT: if (iack_ni) st_d = ST_IDLE;
      default:    st_d = ST_WAIT_HI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_WAIT_HI;
      cap_lvl_o <= '0;
      cap_rd_o  <= 1'b0;
      win_o     <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && !iack_ni) begin
        cap_lvl_o <= level_i;
        cap_rd_o  <= rw_i;
      end
      if (st_q == ST_CHAIN && !iackin_ni) win_o <= win_i;
    end
  end

  always_comb begin
    clr_o = '0;
    if (st_q == ST_VEC && !iack_ni) clr_o[win_o] = 1'b1;
    if (take_ext)                   clr_o[win_i] = 1'b1;
  end

  // releases follow the acknowledge input without waiting for a clock
  assign iackout_no = !(st_q == ST_PASS && !iack_ni);
  assign data_oe_o  = (st_q == ST_VEC || st_q == ST_DTK) && !iack_ni;
  assign dtack_no   = !(st_q == ST_DTK && !iack_ni);
  assign intae_no   = !(st_q == ST_EXT && !iack_ni);

  assert_one_resp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~iackout_no, ~dtack_no, ~intae_no}) <= 1);

  assert_vec_before_dtack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtack_no |-> data_oe_o && $past(data_oe_o));

  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_ni |=> st_q == ST_IDLE);

  assert_rearm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_CHAIN |-> $past(st_q) == ST_IDLE || $past(st_q) == ST_CHAIN);
endmodule

// File: rtl/bus_int_handler.sv
module bus_int_handler
  import bih_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int AW    = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [VEC_W-1:0] reg_wdata_i,
  input  logic [N_SRC-1:0] req_i,
  output logic [N_LVL-1:0] irq_no,
  input  logic             iack_ni,
  input  logic             iackin_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic             rw_i,
  output logic             iackout_no,
  output logic             dtack_no,
  output logic [VEC_W-1:0] data_o,
  output logic             data_oe_o,
  output logic             intae_no,
  output logic [IDX_W-1:0] intal_o
);
  src_cfg_t [N_SRC-1:0]        cfg;
  logic [N_SRC-1:0][VEC_W-1:0] vec;
  logic [N_SRC-1:0]            pend, clr;
  logic [LVL_W-1:0]            cap_lvl;
  logic                        cap_rd, hit, hit_ext;
  logic [IDX_W-1:0]            win_c, win_q;

  bih_regs #(.N_SRC(N_SRC), .VEC_W(VEC_W)) i_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .vec_o(vec)
  );

  bih_req #(.N_SRC(N_SRC)) i_req (
    .clk_i, .rst_ni, .req_i, .clr_i(clr), .cfg_i(cfg), .pend_o(pend), .irq_no
  );

  bih_match #(.N_SRC(N_SRC)) i_match (
    .cfg_i(cfg), .pend_i(pend), .lvl_i(cap_lvl), .rd_i(cap_rd),
    .hit_o(hit), .win_o(win_c), .ext_o(hit_ext)
  );

  bih_ack #(.N_SRC(N_SRC)) i_ack (
    .clk_i, .rst_ni, .iack_ni, .iackin_ni, .level_i, .rw_i,
    .cap_lvl_o(cap_lvl), .cap_rd_o(cap_rd),
    .hit_i(hit), .win_i(win_c), .ext_i(hit_ext),
    .win_o(win_q), .clr_o(clr),
    .iackout_no, .dtack_no, .data_oe_o, .intae_no
  );

  assign data_o  = data_oe_o ? vec[win_q] : '0;
  assign intal_o = win_q;
endmodule

// File: tb/test_bus_int_handler.sv
`timescale 1ns/1ps
module test_bus_int_handler;
  logic       clk = 0, rst_ni = 0;
  logic       reg_we_i = 0;
  logic [2:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [3:0] req_i = 0;
  logic [6:0] irq_no;
  logic       iack_ni = 1, iackin_ni = 1, rw_i = 1;
  logic [2:0] level_i = 0;
  logic       iackout_no, dtack_no, data_oe_o, intae_no;
  logic [7:0] data_o;
  logic [1:0] intal_o;

  int errors = 0, checks = 0;
  bit m_en[4], m_ext[4], m_pend[4];
  int m_lvl[4], m_vec[4];

  always #10 clk = ~clk;

  bus_int_handler i_bus_int_handler (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .req_i, .irq_no,
    .iack_ni, .iackin_ni, .level_i, .rw_i, .iackout_no, .dtack_no, .data_o,
    .data_oe_o, .intae_no, .intal_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " iackout"}, iackout_no, 1);
    chk({req, " dtack"},   dtack_no,   1);
    chk({req, " intae"},   intae_no,   1);
    chk({req, " data_oe"}, data_oe_o,  0);
  endtask

  function automatic int exp_irq();
    int v = 7'h7f;
    for (int i = 0; i < 4; i++)
      if (m_en[i] && m_pend[i] && m_lvl[i] != 0) v &= ~(1 << (m_lvl[i] - 1));
    return v;
  endfunction

  function automatic int exp_win(input int lv, input bit rd);
    if (!rd) return -1;
    for (int i = 0; i < 4; i++)
      if (m_en[i] && m_pend[i] && m_lvl[i] == lv && lv != 0) return i;
    return -1;
  endfunction

  task automatic wr(input int a, input int d);
    reg_we_i = 1; reg_addr_i = 3'(a); reg_wdata_i = 8'(d);
    @(negedge clk);
    reg_we_i = 0;
  endtask

  task automatic run_ack(input int lv, input bit rd, input bit chain);
    int w;
    level_i = 3'(lv); rw_i = rd; iack_ni = 0; iackin_ni = 1;
    @(negedge clk);
    iackin_ni = !chain;
    @(negedge clk);
    w = chain ? exp_win(lv, rd) : -2;
    if (w == -2) chk_idle("R2 no chain");
    else if (w == -1) begin
      chk(rd ? "R3 pass iackout" : "R11 write pass", iackout_no, 0);
      chk("R4 R3 no dtack", dtack_no, 1);
      chk("R3 no intae", intae_no, 1);
    end else if (m_ext[w]) begin
      chk("R6 intae", intae_no, 0);
      chk("R6 R7 intal", intal_o, w);
      chk("R6 no iackout", iackout_no, 1);
      chk("R6 no dtack", dtack_no, 1);
      chk("R6 no data", data_oe_o, 0);
    end else begin
      chk("R5 data_oe", data_oe_o, 1);
      chk("R5 R7 vector", data_o, m_vec[w]);
      chk("R5 dtack late", dtack_no, 1);
      chk("R5 no iackout", iackout_no, 1);
    end
    @(negedge clk);
    if (w >= 0) begin
      if (!m_ext[w]) begin
        chk("R5 dtack", dtack_no, 0);
        chk("R5 vector held", data_o, m_vec[w]);
      end
      m_pend[w] = 0;
    end
    iack_ni = 1; iackin_ni = 1;
    #1 chk_idle("R10 release");
    @(negedge clk);
    @(negedge clk);
    chk("R9 R8 irq after ack", irq_no, exp_irq());
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_en[i]=0; m_ext[i]=0; m_pend[i]=0; m_lvl[i]=0; m_vec[i]=0; end
    // acknowledge held low across reset must not start a cycle
    iack_ni = 0; iackin_ni = 0; level_i = 3;
    #45 rst_ni = 1;
    @(negedge clk);
    chk("R12 reset irq", irq_no, 7'h7f);
    chk_idle("R12 reset");
    @(negedge clk); @(negedge clk);
    chk("R1 no cycle before high", iackout_no, 1);
    iack_ni = 1; iackin_ni = 1;
    @(negedge clk); @(negedge clk);

    for (int t = 0; t < 64; t++) begin
      for (int i = 0; i < 4; i++) begin
        m_lvl[i] = (t + (i >> 1) * (t >> 3)) % 8;
        m_en[i]  = ((t >> i) & 1) || (t % 3 == 0);
        m_ext[i] = ((t + i) >> 1) & 1;
        m_vec[i] = ((t * 4 + i) & 255) ^ 8'hA5;
        wr(i, (m_en[i] << 7) | (m_ext[i] << 3) | m_lvl[i]);
        wr(4 + i, m_vec[i]);
      end
      chk("R12 R4 irq after config", irq_no, exp_irq());
      req_i = 4'hf;
      @(negedge clk);
      req_i = 4'h0;
      for (int i = 0; i < 4; i++) m_pend[i] = 1;
      chk("R8 R9 irq after request", irq_no, exp_irq());
      for (int lv = 1; lv <= 7; lv++)
        run_ack(lv, !(lv == 5 && t % 5 == 2), !(lv == 2 && t % 4 == 1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule